// File: doc/BRIEF.md
# Hiccup-Mode Power Fault Supervisor

This block is the digital fault manager for a controller that drives one switching output and several linear outputs. It takes the over-voltage, over-current and linear under-voltage comparator flags, passes them through synchronizers, and decides when the outputs may run. It also produces the soft-start clamp level that limits the error amplifiers, and it decides when a fault becomes permanent.

The soft-start ramp is a counter that advances on a clock-enable tick and saturates at full scale. A rising over-current flag inhibits every output. The ramp keeps climbing to full scale, is then discharged in one cycle, and a new soft-start cycle begins. This is the retry, or hiccup, cycle. Each discharge counts one over-current event. When the count reaches its limit, the fault latch is set. An over-voltage sets the fault latch at once and asks for the low-side switch to be turned on. A linear under-voltage counts as an over-current, but only once the ramp has reached full scale.

Top module: `hiccup_supervisor`

## Requirements
- R1: While `rst` is high the block clears the fault latch, the event count, the over-current latch and the ramp. With no flags present this gives `out_enable`=1, `fault`=0, `clamp_level`=0 and `force_low_on`=0.
- R2: `clamp_level` rises by exactly one on each clock where `ramp_tick`=1. It holds its value when `ramp_tick`=0 and saturates at 2^RAMP_W-1 (full scale).
- R3: `force_low_on` goes high on the second clock edge after `ov_flag` rises, because of the two synchronizer stages. It stays high as long as the synchronized flag stays high. `fault` goes high on the third edge and needs no counting.
- R4: A rising edge of `oc_flag` drives `out_enable` low from the third clock edge onward. Holding the flag high causes no further event.
- R5: While outputs are inhibited for an over-current, the ramp keeps rising to full scale. At full scale it is cleared to 0 in one cycle, the event count goes up by one, and `out_enable` returns to 1.
- R6: When the event count reaches OC_LIMIT (3 by default), `fault` is set.
- R7: `luv_flag` has no effect while the ramp is below full scale. At full scale it starts an over-current event in the same way as R4 and R5.
- R8: While `fault`=1, `out_enable`=0 and the ramp is held at 0. `fault` stays set until reset or shutdown, even after the flag that set it goes away.
- R9: While `shutdown`=1, `out_enable`=0 and the ramp is held at 0. Shutdown clears the fault latch and the event count, so later events count again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| shutdown | input | 1 | Turns off the controlled outputs and clears fault state |
| ramp_tick | input | 1 | Clock enable for one soft-start ramp step |
| ov_flag | input | 1 | Asynchronous over-voltage comparator flag (switching output) |
| oc_flag | input | 1 | Asynchronous over-current comparator flag (switching output) |
| luv_flag | input | 1 | Asynchronous under-voltage flag of the linear outputs |
| out_enable | output | 1 | High when the outputs are allowed to run |
| clamp_level | output | RAMP_W | Soft-start clamp level for the error amplifiers |
| force_low_on | output | 1 | Request to turn on the low-side switch during over-voltage |
| fault | output | 1 | Latched permanent fault indication |

## Verification
The bench builds the block with RAMP_W=4 and keeps OC_LIMIT=3 and SYNC_STAGES=2. A full soft-start ramp therefore takes 15 ticks. With that short ramp, three complete hiccup cycles, the move into the latched fault and the recovery through shutdown all fit in a few hundred clocks. The short ramp also puts the blanking window for the linear under-voltage flag within a handful of cycles, so both sides of that window can be tested. The exact synchronizer latency is probed edge by edge.

// File: rtl/hic_pkg.sv
package hic_pkg;

    // Synchronized comparator flags, in fixed order
    typedef struct packed {
        logic ov;
        logic oc;
        logic luv;
    } flags_t;

    localparam int unsigned NUM_FLAGS = 3;

    // True when the event now being counted is the one that reaches the limit
    function automatic logic is_final_trip(input int unsigned cnt, input int unsigned limit);
        return (cnt + 1) >= limit;
    endfunction

endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '0;
                else     stg[i] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '0;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/ramp_gen.sv
module ramp_gen #(
    parameter int unsigned RAMP_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold_zero,
    input  logic              discharge,
    input  logic              tick,
    output logic [RAMP_W-1:0] level,
    output logic              full
);
    localparam logic [RAMP_W-1:0] FULL_SCALE = '1;

    assign full = (level == FULL_SCALE);

    always_ff @(posedge clk) begin
        if (rst || hold_zero || discharge) level <= '0;
        else if (tick && !full)            level <= level + RAMP_W'(1);
    end
endmodule

// File: rtl/fault_ctrl.sv
module fault_ctrl
    import hic_pkg::*;
#(
    parameter int unsigned OC_LIMIT = 3,
    parameter int unsigned CNT_W    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shutdown,
    input  flags_t           flags,
    input  logic             ramp_full,
    output logic             fault,
    output logic             oc_latched,
    output logic             discharge,
    output logic [CNT_W-1:0] oc_count
);
    logic oc_prev;
    logic oc_rise;
    logic luv_trip;
    logic fault_next;

    assign oc_rise   = flags.oc & ~oc_prev;
    assign luv_trip  = flags.luv & ramp_full;           // blanked until ramp is full
    assign discharge = oc_latched & ramp_full & ~fault & ~shutdown;

    always_comb begin
        fault_next = fault | flags.ov;
        if (discharge && is_final_trip(int'(oc_count), OC_LIMIT))
            fault_next = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) oc_prev <= 1'b0;
        else     oc_prev <= flags.oc;
    end

    always_ff @(posedge clk) begin
        if (rst || shutdown) begin
            fault      <= 1'b0;
            oc_latched <= 1'b0;
            oc_count   <= '0;
        end else begin
            fault <= fault_next;
            if (discharge && oc_count != CNT_W'(OC_LIMIT))
                oc_count <= oc_count + CNT_W'(1);
            if (fault_next)                oc_latched <= 1'b0;
            else if (oc_rise || luv_trip)  oc_latched <= 1'b1;
            else if (discharge)            oc_latched <= 1'b0;
        end
    end
endmodule

// File: rtl/hiccup_supervisor.sv
module hiccup_supervisor
    import hic_pkg::*;
#(
    parameter int unsigned RAMP_W      = 10,
    parameter int unsigned OC_LIMIT    = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shutdown,
    input  logic              ramp_tick,
    input  logic              ov_flag,
    input  logic              oc_flag,
    input  logic              luv_flag,
    output logic              out_enable,
    output logic [RAMP_W-1:0] clamp_level,
    output logic              force_low_on,
    output logic              fault
);
    localparam int unsigned CNT_W = $clog2(OC_LIMIT + 1);

    flags_t           raw_flags;
    flags_t           sync_flags;
    logic [NUM_FLAGS-1:0] sync_bits;
    logic             ramp_full;
    logic             oc_latched;
    logic             discharge;
    logic [CNT_W-1:0] oc_count;

    assign raw_flags  = '{ov: ov_flag, oc: oc_flag, luv: luv_flag};
    assign sync_flags = flags_t'(sync_bits);

    flag_sync #(.WIDTH(NUM_FLAGS), .STAGES(SYNC_STAGES)) sync_i (
        .clk (clk),
        .rst (rst),
        .din (raw_flags),
        .dout(sync_bits)
    );

    ramp_gen #(.RAMP_W(RAMP_W)) ramp_i (
        .clk      (clk),
        .rst      (rst),
        .hold_zero(fault | shutdown),
        .discharge(discharge),
        .tick     (ramp_tick),
        .level    (clamp_level),
        .full     (ramp_full)
    );

    fault_ctrl #(.OC_LIMIT(OC_LIMIT), .CNT_W(CNT_W)) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .shutdown  (shutdown),
        .flags     (sync_flags),
        .ramp_full (ramp_full),
        .fault     (fault),
        .oc_latched(oc_latched),
        .discharge (discharge),
        .oc_count  (oc_count)
    );

    assign out_enable   = ~fault & ~oc_latched & ~shutdown;
    assign force_low_on = sync_flags.ov;
endmodule

// File: rtl/hiccup_supervisor_chk.sv
module hiccup_supervisor_chk #(
    parameter int unsigned RAMP_W   = 10,
    parameter int unsigned OC_LIMIT = 3,
    parameter int unsigned CNT_W    = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              shutdown,
    input logic              fault,
    input logic [RAMP_W-1:0] clamp_level,
    input logic              force_low_on,
    input logic [CNT_W-1:0]  oc_count
);
    // R2: ramp only steps by one, holds, or discharges to zero
    p_ramp_step_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (clamp_level == $past(clamp_level) + RAMP_W'(1)) ||
                 (clamp_level == $past(clamp_level)) || (clamp_level == '0));

    // R3: a synchronized over-voltage latches the fault on the next edge
    p_ov_latch_r3: assert property (@(posedge clk) disable iff (rst)
        force_low_on && !shutdown |=> fault);

    // R8: fault is sticky without shutdown
    p_fault_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        fault && !shutdown |=> fault);

    // R8: fault holds the ramp at zero
    p_fault_ramp_r8: assert property (@(posedge clk) disable iff (rst)
        fault |=> clamp_level == '0);

    // R6: the count never passes the limit, and reaching it means fault
    p_count_bound_r6: assert property (@(posedge clk) disable iff (rst)
        oc_count <= CNT_W'(OC_LIMIT));
    p_limit_fault_r6: assert property (@(posedge clk) disable iff (rst)
        oc_count == CNT_W'(OC_LIMIT) |-> fault);

    // R9: shutdown clears fault and ramp
    p_shutdown_clear_r9: assert property (@(posedge clk) disable iff (rst)
        shutdown |=> !fault && clamp_level == '0 && oc_count == '0);
endmodule

bind hiccup_supervisor hiccup_supervisor_chk #(
    .RAMP_W(RAMP_W), .OC_LIMIT(OC_LIMIT), .CNT_W(CNT_W)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .shutdown    (shutdown),
    .fault       (fault),
    .clamp_level (clamp_level),
    .force_low_on(force_low_on),
    .oc_count    (oc_count)
);

// File: tb/hiccup_supervisor_tb_top.sv
module hiccup_supervisor_tb_top;
    localparam int RW = 4;

    logic clk = 1'b0;
    logic rst, shutdown, ramp_tick, ov_flag, oc_flag, luv_flag;
    logic out_enable, force_low_on, fault;
    logic [RW-1:0] clamp_level;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;  // 50 MHz

    hiccup_supervisor #(.RAMP_W(RW), .OC_LIMIT(3), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .shutdown(shutdown), .ramp_tick(ramp_tick),
        .ov_flag(ov_flag), .oc_flag(oc_flag), .luv_flag(luv_flag),
        .out_enable(out_enable), .clamp_level(clamp_level),
        .force_low_on(force_low_on), .fault(fault)
    );

    typedef struct packed {
        logic       sd, ov, oc, luv;
        logic       en, flt, frc;
        logic [3:0] clamp;
    } vec_t;

    // Each row: apply inputs, wait 40 clocks, compare settled outputs
    localparam vec_t VECS [11] = '{
        '{1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,4'd15},  // R2 idle ramp full
        '{1'b0,1'b0,1'b1,1'b0, 1'b1,1'b0,1'b0,4'd15},  // R5 first trip, count 1
        '{1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,4'd15},  // R4 release
        '{1'b0,1'b0,1'b1,1'b0, 1'b1,1'b0,1'b0,4'd15},  // R5 second trip, count 2
        '{1'b0,1'b0,1'b0,1'b1, 1'b0,1'b1,1'b0,4'd0 },  // R7/R6 luv at full -> third
        '{1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,4'd0 },  // R9 shutdown
        '{1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,4'd15},  // R9 recover
        '{1'b0,1'b1,1'b0,1'b0, 1'b0,1'b1,1'b1,4'd0 },  // R3 over-voltage
        '{1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,4'd0 },  // R8 sticky
        '{1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,4'd0 },  // R9 shutdown clears
        '{1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,4'd15}   // R9 restart
    };

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; shutdown = 1'b0; ov_flag = 1'b0; oc_flag = 1'b0; luv_flag = 1'b0;
        ramp_tick = 1'b1;
        step(3);
        rst = 1'b0;
    endtask

    task automatic oc_trip();
        oc_flag = 1'b1; step(40);
        oc_flag = 1'b0; step(10);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        rst = 1'b1; shutdown = 1'b0; ramp_tick = 1'b1;
        ov_flag = 1'b0; oc_flag = 1'b0; luv_flag = 1'b0;
        step(3);
        // R1 reset state
        chk(16'(out_enable), 16'd1, "R1 enable in reset");
        chk(16'(fault), 16'd0, "R1 fault in reset");
        chk(16'(clamp_level), 16'd0, "R1 clamp in reset");
        chk(16'(force_low_on), 16'd0, "R1 force in reset");
        rst = 1'b0;

        foreach (VECS[i]) begin
            shutdown = VECS[i].sd; ov_flag = VECS[i].ov;
            oc_flag = VECS[i].oc;  luv_flag = VECS[i].luv;
            step(40);
            chk(16'(out_enable), 16'(VECS[i].en), $sformatf("vector %0d enable", i));
            chk(16'(fault), 16'(VECS[i].flt), $sformatf("vector %0d fault", i));
            chk(16'(force_low_on), 16'(VECS[i].frc), $sformatf("vector %0d force", i));
            chk(16'(clamp_level), 16'(VECS[i].clamp), $sformatf("vector %0d clamp", i));
        end

        // R2 tick gating and saturation
        do_reset();
        ramp_tick = 1'b0; step(10);
        chk(16'(clamp_level), 16'd0, "R2 hold without tick");
        ramp_tick = 1'b1; step(5);
        chk(16'(clamp_level), 16'd5, "R2 five ticks");
        ramp_tick = 1'b0; step(5);
        chk(16'(clamp_level), 16'd5, "R2 hold mid ramp");
        ramp_tick = 1'b1; step(40);
        chk(16'(clamp_level), 16'd15, "R2 saturate");

        // R7 blanking: luv during the ramp is ignored
        do_reset();
        luv_flag = 1'b1; step(8);
        luv_flag = 1'b0; step(40);
        chk(16'(out_enable), 16'd1, "R7 blanked luv enable");
        chk(16'(clamp_level), 16'd15, "R7 blanked luv clamp");
        oc_trip(); oc_trip();
        chk(16'(fault), 16'd0, "R7 luv not counted");
        oc_trip();
        chk(16'(fault), 16'd1, "R6 third event faults");
        chk(16'(out_enable), 16'd0, "R8 fault disables");

        // R4 latency and R5 ramp continues while inhibited
        do_reset();
        step(3);
        oc_flag = 1'b1;
        step(2);
        chk(16'(out_enable), 16'd1, "R4 enable before latency");
        step(1);
        chk(16'(out_enable), 16'd0, "R4 inhibit on third edge");
        begin
            logic [RW-1:0] c1;
            c1 = clamp_level;
            step(3);
            chk(16'(clamp_level), 16'(c1 + 4'd3), "R5 ramp rises while inhibited");
        end
        step(1);
        chk(16'(out_enable), 16'd0, "R4 held level no retrigger");
        step(25);
        chk(16'(out_enable), 16'd1, "R5 re-enabled after discharge");
        chk(16'(fault), 16'd0, "R5 one event no fault");

        // R3 over-voltage latency
        do_reset();
        oc_flag = 1'b0; step(40);
        ov_flag = 1'b1;
        step(2);
        chk(16'(force_low_on), 16'd1, "R3 force after two edges");
        chk(16'(fault), 16'd0, "R3 fault not yet");
        step(1);
        chk(16'(fault), 16'd1, "R3 fault on third edge");
        ov_flag = 1'b0; step(10);
        chk(16'(force_low_on), 16'd0, "R3 force released");
        chk(16'(fault), 16'd1, "R8 fault sticky");
        chk(16'(clamp_level), 16'd0, "R8 ramp held zero");

        // R9 shutdown clears the event count
        do_reset();
        step(40);
        oc_trip(); oc_trip();
        shutdown = 1'b1; step(3);
        chk(16'(out_enable), 16'd0, "R9 shutdown disables");
        shutdown = 1'b0; step(40);
        oc_trip(); oc_trip();
        chk(16'(fault), 16'd0, "R9 count cleared by shutdown");
        oc_trip();
        chk(16'(fault), 16'd1, "R6 limit after shutdown");

        summary();
    end
endmodule